// File: doc/BRIEF.md
# Frame-Synchronous Window Configuration Register Bank

This block keeps the per-window configuration of a multi-window display controller in two copies. Software writes and reads back the active copy over a simple single-cycle register bus. The scan-out logic sees only the shadow copy. The active values move into the shadow copy at a vertical sync pulse, which is also the point where the fetch engine starts a new frame. As a result, a frame is never scanned with a half-written configuration.

Each window has a protect bit. While that bit is set, the vsync copy skips the window. Software can therefore update several registers of one window across many cycles, or even across frame boundaries, and release them all together. The per-window DMA channel enables are held in the same two copies. Clearing a channel therefore stops scan-out only at the next frame boundary. A parameter selects a variant with one global protect bit that holds back every window at once.

The default build has five windows, numbered 0 to 4. Each window has four 32-bit registers, and there is one control register. A write that lands in the vsync cycle is taken into the active copy and reaches the shadow one frame later.

Top module: `shadow_bank`

## Requirements
- R1: After reset, every readable register reads 0, every shadow register is 0 and every shadowed channel enable is 0.
- R2: A write to a window register changes the active copy. The new value reads back on the next cycle. The shadow copy does not change until a vsync. The active copy changes only on a bus write.
- R3: On a clock edge where `vsync_i` is high and a window is not protected, that window's shadow registers take the active values. The result is visible on the following cycle.
- R4: A write in the same cycle as a vsync updates the active copy, and the shadow copy receives the value held before that write. The written value reaches the shadow copy at the next vsync.
- R5: While a window's protect bit is set, a vsync leaves that window's shadow registers and its shadowed channel enable unchanged. Unprotected windows still update at the same vsync.
- R6: Clearing a protect bit transfers nothing at that moment. The pending values and the pending channel enable move into the shadow copy at the next vsync.
- R7: Control register bits [4:0] are the channel enables for windows 0 to 4. A set or cleared enable appears on `shd_chan_en_o` only after the next vsync, and the shadowed enables change at no other time.
- R8: When `GLOBAL_PROT` is 1, only control bit 5 is a protect bit, and it holds back all windows together. Bits [9:6] read as 0 and have no effect.
- R9: Register r of window w sits at address w*4+r. The control register is at address 20. In per-window mode, bits [9:5] of the control register are the protect bits for windows 0 to 4. A write above address 20 changes nothing, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vsync_i | input | 1 | Frame-start pulse; shadow copy taken on edges where high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address for write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Active-copy read data for `addr_i` (combinational) |
| shd_cfg_o | output | 640 | Shadow registers, window w register r at bits [(w*4+r)*32 +: 32] |
| shd_chan_en_o | output | 5 | Shadowed channel enables, one per window |

## Verification
The properties assume that `vsync_i` and the bus signals are synchronous to `clk_i` and stable around the rising edge. They also assume that `addr_i` is held steady for the whole cycle in which `rdata_o` is observed. The stimulus drives every input on the falling edge and samples outputs one time step later, so these conditions hold throughout. Each vsync pulse lasts exactly one clock cycle. A second instance in global-protect mode shares the same bus, and its expectations are computed from its own control-bit meaning.

// File: rtl/shadow_bank_pkg.sv
`timescale 1ns/1ps
package shadow_bank_pkg;
  localparam int unsigned DEF_NUM_WIN = 5;
  localparam int unsigned DEF_NREG    = 4;
  localparam int unsigned DEF_DATA_W  = 32;

  // width of the protect field for a variant
  function automatic int unsigned prot_width(input int unsigned num_win, input bit global_prot);
    return global_prot ? 1 : num_win;
  endfunction
endpackage

// File: rtl/sb_win_regs.sv
`timescale 1ns/1ps
module sb_win_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREG   = 4,
  localparam int unsigned SEL_W = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   latch_i,
  output logic [NREG*DATA_W-1:0] act_o,
  output logic [NREG*DATA_W-1:0] shd_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DATA_W-1:0] act_q, shd_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q <= '0;
      end else if (we_i && sel_i == SEL_W'(r)) begin
        act_q <= wdata_i;
      end
    end

    // old active value goes to shadow even if written this cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_q <= '0;
      end else if (latch_i) begin
        shd_q <= act_q;
      end
    end

    assign act_o[r*DATA_W +: DATA_W] = act_q;
    assign shd_o[r*DATA_W +: DATA_W] = shd_q;
  end
endmodule

// File: rtl/sb_ctrl.sv
`timescale 1ns/1ps
module sb_ctrl #(
  parameter int unsigned NUM_WIN     = 5,
  parameter int unsigned DATA_W      = 32,
  parameter bit          GLOBAL_PROT = 1'b0,
  localparam int unsigned PW = shadow_bank_pkg::prot_width(NUM_WIN, GLOBAL_PROT)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [NUM_WIN+PW-1:0] wdata_i,
  input  logic                  vsync_i,
  output logic [DATA_W-1:0]     rd_o,
  output logic [NUM_WIN-1:0]    prot_eff_o,
  output logic [NUM_WIN-1:0]    latch_o,
  output logic [NUM_WIN-1:0]    chan_shd_o
);
  logic [NUM_WIN-1:0] chan_q;
  logic [PW-1:0]      prot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= '0;
      prot_q <= '0;
    end else if (we_i) begin
      chan_q <= wdata_i[NUM_WIN-1:0];
      prot_q <= wdata_i[NUM_WIN +: PW];
    end
  end

  if (GLOBAL_PROT) begin : g_global
    assign prot_eff_o = {NUM_WIN{prot_q[0]}};
  end else begin : g_per_win
    assign prot_eff_o = prot_q;
  end

  assign latch_o = {NUM_WIN{vsync_i}} & ~prot_eff_o;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_chan
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chan_shd_o[w] <= 1'b0;
      end else if (latch_o[w]) begin
        chan_shd_o[w] <= chan_q[w];
      end
    end
  end

  always_comb begin
    rd_o = '0;
    rd_o[NUM_WIN-1:0]   = chan_q;
    rd_o[NUM_WIN +: PW] = prot_q;
  end
endmodule

// File: rtl/sb_rd_mux.sv
`timescale 1ns/1ps
module sb_rd_mux #(
  parameter int unsigned NUM_WIN = 5,
  parameter int unsigned NREG    = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5,
  localparam int unsigned NTOT   = NUM_WIN * NREG
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [NTOT*DATA_W-1:0] act_i,
  input  logic [DATA_W-1:0]      ctrl_i,
  output logic [DATA_W-1:0]      rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NTOT; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = act_i[i*DATA_W +: DATA_W];
    end
    if (addr_i == ADDR_W'(NTOT)) rdata_o = ctrl_i;
  end
endmodule

// File: rtl/shadow_bank.sv
`timescale 1ns/1ps
module shadow_bank #(
  parameter int unsigned NUM_WIN     = shadow_bank_pkg::DEF_NUM_WIN,
  parameter int unsigned NREG        = shadow_bank_pkg::DEF_NREG,
  parameter int unsigned DATA_W      = shadow_bank_pkg::DEF_DATA_W,
  parameter bit          GLOBAL_PROT = 1'b0,
  parameter int unsigned ADDR_W      = $clog2(NUM_WIN*NREG+1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          vsync_i,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NUM_WIN*NREG*DATA_W-1:0] shd_cfg_o,
  output logic [NUM_WIN-1:0]            shd_chan_en_o
);
  localparam int unsigned SEL_W  = $clog2(NREG);
  localparam int unsigned WSEL_W = ADDR_W - SEL_W;
  localparam int unsigned NTOT   = NUM_WIN * NREG;
  localparam int unsigned WIN_W  = NREG * DATA_W;
  localparam int unsigned PW     = shadow_bank_pkg::prot_width(NUM_WIN, GLOBAL_PROT);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NTOT);

  logic [NTOT*DATA_W-1:0] act_all;
  logic [NUM_WIN-1:0]     prot_eff;
  logic [NUM_WIN-1:0]     latch;
  logic [DATA_W-1:0]      ctrl_rd;
  logic [WSEL_W-1:0]      win_sel;
  logic                   win_range;
  logic                   ctrl_we;

  assign win_sel   = addr_i[ADDR_W-1:SEL_W];
  assign win_range = addr_i < CTRL_ADDR;
  assign ctrl_we   = wr_en_i && addr_i == CTRL_ADDR;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic we;
    assign we = wr_en_i && win_range && win_sel == WSEL_W'(w);

    sb_win_regs #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we),
      .sel_i   (addr_i[SEL_W-1:0]),
      .wdata_i (wdata_i),
      .latch_i (latch[w]),
      .act_o   (act_all[w*WIN_W +: WIN_W]),
      .shd_o   (shd_cfg_o[w*WIN_W +: WIN_W])
    );
  end

  sb_ctrl #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .GLOBAL_PROT(GLOBAL_PROT)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctrl_we),
    .wdata_i    (wdata_i[NUM_WIN+PW-1:0]),
    .vsync_i    (vsync_i),
    .rd_o       (ctrl_rd),
    .prot_eff_o (prot_eff),
    .latch_o    (latch),
    .chan_shd_o (shd_chan_en_o)
  );

  sb_rd_mux #(.NUM_WIN(NUM_WIN), .NREG(NREG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .addr_i  (addr_i),
    .act_i   (act_all),
    .ctrl_i  (ctrl_rd),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/sb_checker.sv
`timescale 1ns/1ps
module sb_checker #(
  parameter int unsigned NUM_WIN     = 5,
  parameter int unsigned NREG        = 4,
  parameter int unsigned DATA_W      = 32,
  parameter bit          GLOBAL_PROT = 1'b0,
  parameter int unsigned ADDR_W      = 5,
  localparam int unsigned WIN_W      = NREG * DATA_W
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         vsync_i,
  input logic                         wr_en_i,
  input logic [ADDR_W-1:0]            addr_i,
  input logic [DATA_W-1:0]            rdata_o,
  input logic [NUM_WIN*WIN_W-1:0]     act_all,
  input logic [NUM_WIN*WIN_W-1:0]     shd_cfg_o,
  input logic [NUM_WIN-1:0]           prot_eff,
  input logic [NUM_WIN-1:0]           shd_chan_en_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_WIN*NREG);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_w
    a_r3_copy_at_vsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vsync_i && !prot_eff[w] |=> shd_cfg_o[w*WIN_W +: WIN_W] == $past(act_all[w*WIN_W +: WIN_W]));
    a_r5_hold_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!vsync_i || prot_eff[w]) |=> $stable(shd_cfg_o[w*WIN_W +: WIN_W]));
    a_r5_hold_chan: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prot_eff[w] |=> $stable(shd_chan_en_o[w]));
  end

  a_r7_chan_only_at_vsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_i |=> $stable(shd_chan_en_o));

  a_r2_active_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(act_all));

  a_r9_oob_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i > CTRL_ADDR |-> rdata_o == '0);

  if (GLOBAL_PROT) begin : g_glob
    a_r8_all_or_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(prot_eff) == 0 || $countones(prot_eff) == NUM_WIN);
  end
endmodule

bind shadow_bank sb_checker #(
  .NUM_WIN(NUM_WIN), .NREG(NREG), .DATA_W(DATA_W),
  .GLOBAL_PROT(GLOBAL_PROT), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .vsync_i       (vsync_i),
  .wr_en_i       (wr_en_i),
  .addr_i        (addr_i),
  .rdata_o       (rdata_o),
  .act_all       (act_all),
  .shd_cfg_o     (shd_cfg_o),
  .prot_eff      (prot_eff),
  .shd_chan_en_o (shd_chan_en_o)
);

// File: tb/tb_shadow_bank.sv
`timescale 1ns/1ps
module tb_shadow_bank;
  localparam int NW = 5, NR = 4, DW = 32, AW = 5;

  logic clk = 1'b0, rst_n = 1'b0, vsync = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, rdata_g;
  logic [NW*NR*DW-1:0] shd, shd_g;
  logic [NW-1:0] chan, chan_g;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shadow_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .vsync_i(vsync), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .shd_cfg_o(shd), .shd_chan_en_o(chan));

  shadow_bank #(.GLOBAL_PROT(1'b1)) dut_g (
    .clk_i(clk), .rst_ni(rst_n), .vsync_i(vsync), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_g), .shd_cfg_o(shd_g), .shd_chan_en_o(chan_g));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] sreg(input logic [NW*NR*DW-1:0] v, input int w, input int r);
    return v[(w*NR+r)*DW +: DW];
  endfunction

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0; #1;
  endtask

  task automatic pulse_vsync();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0; #1;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d, output logic [DW-1:0] dg);
    @(negedge clk); addr = AW'(a); #1; d = rdata; dg = rdata_g;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d, dg;
    for (int a = 0; a <= 20; a += 5) begin
      rd(a, d, dg); chk("R1 reset read", d, '0);
    end
    chk("R1 reset shadow w0r0", sreg(shd, 0, 0), '0);
    chk("R1 reset shadow w4r3", sreg(shd, 4, 3), '0);
    chk("R1 reset chan", DW'(chan), '0);
  endtask

  task automatic t_write_read();
    logic [DW-1:0] d, dg;
    wr(2*4+1, 32'hA5A5_0001);
    rd(9, d, dg); chk("R2 readback w2r1", d, 32'hA5A5_0001);
    chk("R2 shadow unchanged before vsync", sreg(shd, 2, 1), '0);
    wr(21, 32'hFFFF_FFFF);
    rd(21, d, dg); chk("R9 out-of-range read", d, '0);
    rd(20, d, dg); chk("R9 ctrl untouched by oob write", d, '0);
    rd(9, d, dg); chk("R9 w2r1 untouched by oob write", d, 32'hA5A5_0001);
  endtask

  task automatic t_vsync_copy();
    pulse_vsync();
    chk("R3 shadow w2r1 after vsync", sreg(shd, 2, 1), 32'hA5A5_0001);
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] d, dg;
    @(negedge clk); wr_en = 1'b1; addr = AW'(0); wdata = 32'h1234_5678; vsync = 1'b1;
    @(negedge clk); wr_en = 1'b0; vsync = 1'b0; #1;
    chk("R4 shadow keeps old value", sreg(shd, 0, 0), '0);
    rd(0, d, dg); chk("R4 active took write", d, 32'h1234_5678);
    pulse_vsync();
    chk("R4 value lands next vsync", sreg(shd, 0, 0), 32'h1234_5678);
  endtask

  task automatic t_protect();
    logic [DW-1:0] d, dg;
    wr(20, (32'h1 << 6) | 32'h0A);   // protect w1, enable ch1, ch3
    wr(1*4+0, 32'hB0B0_0001);
    wr(3*4+0, 32'hC0C0_0003);
    chk("R7 chan not yet visible", DW'(chan), '0);
    pulse_vsync();
    chk("R5 protected w1 held", sreg(shd, 1, 0), '0);
    chk("R5 unprotected w3 updated", sreg(shd, 3, 0), 32'hC0C0_0003);
    chk("R5 R7 chan: w3 on, w1 held", DW'(chan), 32'h08);
    wr(20, 32'h0A);                    // release protect
    chk("R6 no transfer at clear", sreg(shd, 1, 0), '0);
    rd(20, d, dg); chk("R9 ctrl readback", d, 32'h0A);
    pulse_vsync();
    chk("R6 pending w1 transferred", sreg(shd, 1, 0), 32'hB0B0_0001);
    chk("R6 pending chan transferred", DW'(chan), 32'h0A);
  endtask

  task automatic t_chan_clear();
    wr(20, 32'h0);
    chk("R7 clear waits for vsync", DW'(chan), 32'h0A);
    pulse_vsync();
    chk("R7 cleared after vsync", DW'(chan), 32'h0);
  endtask

  task automatic t_global();
    logic [DW-1:0] d, dg;
    wr(20, (32'h1 << 5) | (32'h1 << 7));
    rd(20, d, dg); chk("R8 global ctrl readback", dg, 32'h20);
    chk("R9 per-window ctrl readback", d, 32'hA0);
    wr(4*4+3, 32'hD00D_0004);
    pulse_vsync();
    chk("R8 global protect holds w4", sreg(shd_g, 4, 3), '0);
    chk("R5 per-window w4 not protected", sreg(shd, 4, 3), 32'hD00D_0004);
    wr(20, 32'h0);
    pulse_vsync();
    chk("R8 global release transfers", sreg(shd_g, 4, 3), 32'hD00D_0004);
  endtask

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_vsync_copy();
    t_same_cycle();
    t_protect();
    t_chan_clear();
    t_global();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule